// File: doc/BRIEF.md
# Stall-Tolerant Core Test Wrapper Controller

This block steers the wrapper scan chains of an embedded core whose test stimulus arrives over an on-chip network. The network doubles as the test access path. Stimulus comes in 32-bit flits. The controller unpacks each flit into groups of serial bits, one bit per wrapper chain per shift cycle. It packs the bits the chains shift out back into 32-bit response flits, which leave through a valid/ready output. Flit retransmission upstream or downstream can delay traffic by tens of cycles. When an input flit is missing, or the output cannot take a finished response flit, the controller parks in a dedicated pause state with the scan clock enable low. It resumes later without dropping or repeating a scan bit.

A job starts with a `start` pulse. The job runs `patCount + 1` shift phases of `shiftLen` shift cycles each, with a one-cycle capture after each of the first `patCount` phases. The first phase only loads stimulus and the last one only unloads responses. After the final response flit has been accepted downstream, `done` pulses once.

Top module: `stwWrapperCtl`

## Requirements
- R1: After reset, `inReady`, `outValid`, `scanEn`, `scanClkEn`, `captureEn` and `done` are all low.
- R2: Each shift cycle drives `scanIn` with the next 4-bit group of the current input flit, least significant group first (group g is bits [4g+3:4g]). A flit is accepted (`inValid && inReady`) only in a cycle that also shifts its first group. Bits of a phase's last flit that are left over after `shiftLen` shifts are discarded, so every phase consumes exactly ceil(4*shiftLen/32) flits.
- R3: Every shift phase makes exactly `shiftLen` shift cycles (`scanClkEn` high), however the flow stalls. While the controller is paused, `scanClkEn` is low and `scanEn` stays high.
- R4: When a shift needs a new flit and `inValid` is low, shifting pauses (input pause). It resumes on the cycle after `inValid` goes high.
- R5: When the response packing register is full and a previously issued response flit is still waiting (`outValid && !outReady`), shifting pauses (output pause). It resumes on the cycle after `outReady` goes high. If both stall causes are present, the output pause is taken.
- R6: Response flits carry the `scanOut` groups in shift order, the first shifted group in bits [3:0]. The last flit of each phase is zero-padded above its final group. While `outValid && !outReady`, `outFlit` and `outValid` hold.
- R7: `captureEn` is high for exactly one cycle after each of the first `patCount` phases, and never during shifting. A job has `patCount + 1` phases.
- R8: With `patCount = 0`, a job runs a single unload phase and no capture.
- R9: `done` is a single-cycle pulse, asserted only after every response flit of the job has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse that begins a job while idle |
| shiftLen | input | 16 | Shift cycles per phase (wrapper chain length) |
| patCount | input | 16 | Number of patterns (captures) in the job |
| inFlit | input | 32 | Incoming stimulus flit |
| inValid | input | 1 | Stimulus flit present |
| inReady | output | 1 | Stimulus flit taken this cycle |
| outFlit | output | 32 | Outgoing response flit |
| outValid | output | 1 | Response flit present |
| outReady | input | 1 | Downstream takes the response flit |
| scanEn | output | 1 | Chains in shift mode |
| scanClkEn | output | 1 | Chain clock enable for one shift |
| captureEn | output | 1 | Chains capture core responses |
| scanIn | output | 4 | Serial inputs, one per chain |
| scanOut | input | 4 | Serial outputs, one per chain |
| done | output | 1 | Job finished and drained |

## Verification
A wrong shift counter or a leak through a pause state changes the number of `scanClkEn` cycles in a phase. It also misaligns response groups against the stimulus of the previous phase, so the first response flit of the next phase already miscompares. A wrong unpack or pack index shows up in the first flit of the affected phase. A bad handshake shows as a changed `outFlit` during backpressure or as a missing or extra flit before `done`. The bench pairs long input gaps and long output stalls, alone and together, with a chain model that inverts its contents at capture. Under that pairing, each of these faults surfaces within one phase.

// File: rtl/stwPkg.sv
package stwPkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_HALT_IN,
    ST_HALT_OUT,
    ST_FLUSH,
    ST_CAPTURE,
    ST_DRAIN,
    ST_DONE
  } ctlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shift;    // one shift cycle of the chains
    logic flush;    // move packing register to output register
    logic phaseEnd; // discard unused input bits
  } dpStrobe_t;
endpackage

// File: rtl/stwDatapath.sv
module stwDatapath
  import stwPkg::*;
#(
  parameter int FLIT_W     = 32,
  parameter int NUM_CHAINS = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStrobe_t             strb,
  input  logic [FLIT_W-1:0]     inFlit,
  input  logic                  outReady,
  input  logic [NUM_CHAINS-1:0] scanOut,
  output logic [NUM_CHAINS-1:0] scanIn,
  output logic                  inHave,
  output logic                  accFull,
  output logic                  accEmpty,
  output logic                  canFlush,
  output logic [FLIT_W-1:0]     outFlit,
  output logic                  outValid
);
  localparam int GROUPS = FLIT_W / NUM_CHAINS;
  localparam int CW     = $clog2(GROUPS + 1);

  logic [FLIT_W-1:0] inBuf;
  logic [CW-1:0]     inCnt;
  logic [FLIT_W-1:0] acc;
  logic [CW-1:0]     accCnt;
  logic [FLIT_W-1:0] curWord;

  assign inHave   = (inCnt != '0);
  assign curWord  = inHave ? inBuf : inFlit;
  assign scanIn   = curWord[NUM_CHAINS-1:0];
  assign accFull  = (accCnt == CW'(GROUPS));
  assign accEmpty = (accCnt == '0);
  assign canFlush = !outValid || outReady;

  // input unpacking: a fresh flit is shifted from directly, the rest buffered
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inBuf <= '0;
      inCnt <= '0;
    end else if (strb.phaseEnd) begin
      inCnt <= '0;
    end else if (strb.shift) begin
      inBuf <= curWord >> NUM_CHAINS;
      inCnt <= inHave ? inCnt - 1'b1 : CW'(GROUPS - 1);
    end
  end

  // response packing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc    <= '0;
      accCnt <= '0;
    end else if (strb.flush && strb.shift) begin
      acc    <= FLIT_W'(scanOut);
      accCnt <= CW'(1);
    end else if (strb.flush) begin
      acc    <= '0;
      accCnt <= '0;
    end else if (strb.shift) begin
      acc    <= acc | (FLIT_W'(scanOut) << (accCnt * NUM_CHAINS));
      accCnt <= accCnt + 1'b1;
    end
  end

  // output register with valid/ready
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outFlit  <= '0;
      outValid <= 1'b0;
    end else if (strb.flush) begin
      outFlit  <= acc;
      outValid <= 1'b1;
    end else if (outReady) begin
      outValid <= 1'b0;
    end
  end
endmodule

// File: rtl/stwControl.sv
module stwControl
  import stwPkg::*;
#(
  parameter int LEN_W = 16,
  parameter int PAT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [LEN_W-1:0] shiftLen,
  input  logic [PAT_W-1:0] patCount,
  input  logic             inValid,
  input  logic             outReady,
  input  logic             inHave,
  input  logic             accFull,
  input  logic             accEmpty,
  input  logic             canFlush,
  input  logic             outValid,
  output dpStrobe_t        strb,
  output ctlState_t        state,
  output logic             inReady,
  output logic             scanEn,
  output logic             scanClkEn,
  output logic             captureEn,
  output logic             done
);
  ctlState_t        nextState;
  logic [LEN_W-1:0] shiftLeft;
  logic [PAT_W-1:0] patLeft;
  logic             inAvail;
  logic             outRoom;
  logic             shiftNow;

  assign inAvail  = inHave || inValid;
  assign outRoom  = !accFull || canFlush;
  assign shiftNow = (state == ST_SHIFT) && (shiftLeft != '0) && inAvail && outRoom;

  assign strb.shift    = shiftNow;
  assign strb.flush    = (shiftNow && accFull) ||
                         ((state == ST_FLUSH) && !accEmpty && canFlush);
  assign strb.phaseEnd = (state == ST_SHIFT) && (shiftLeft == '0);

  assign inReady   = shiftNow && !inHave;
  assign scanClkEn = shiftNow;
  assign scanEn    = (state == ST_SHIFT) || (state == ST_HALT_IN) || (state == ST_HALT_OUT);
  assign captureEn = (state == ST_CAPTURE);
  assign done      = (state == ST_DONE);

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:     if (start) nextState = ST_SHIFT;
      ST_SHIFT: begin
        if (shiftLeft == '0)  nextState = ST_FLUSH;
        else if (!outRoom)    nextState = ST_HALT_OUT; // output stall wins
        else if (!inAvail)    nextState = ST_HALT_IN;
      end
      ST_HALT_IN:  if (inValid)  nextState = ST_SHIFT;
      ST_HALT_OUT: if (outReady) nextState = ST_SHIFT;
      ST_FLUSH: begin
        if (accEmpty || canFlush)
          nextState = (patLeft != '0) ? ST_CAPTURE : ST_DRAIN;
      end
      ST_CAPTURE:  nextState = ST_SHIFT;
      ST_DRAIN:    if (!outValid) nextState = ST_DONE;
      ST_DONE:     nextState = ST_IDLE;
      default:     nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      shiftLeft <= '0;
      patLeft   <= '0;
    end else begin
      state <= nextState;
      if (state == ST_IDLE && start) begin
        shiftLeft <= shiftLen;
        patLeft   <= patCount;
      end else if (state == ST_CAPTURE) begin
        shiftLeft <= shiftLen;
        patLeft   <= patLeft - 1'b1;
      end else if (shiftNow) begin
        shiftLeft <= shiftLeft - 1'b1;
      end
    end
  end
endmodule

// File: rtl/stwWrapperCtl.sv
module stwWrapperCtl
  import stwPkg::*;
#(
  parameter int FLIT_W     = 32,
  parameter int NUM_CHAINS = 4,
  parameter int LEN_W      = 16,
  parameter int PAT_W      = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic [LEN_W-1:0]      shiftLen,
  input  logic [PAT_W-1:0]      patCount,
  input  logic [FLIT_W-1:0]     inFlit,
  input  logic                  inValid,
  output logic                  inReady,
  output logic [FLIT_W-1:0]     outFlit,
  output logic                  outValid,
  input  logic                  outReady,
  output logic                  scanEn,
  output logic                  scanClkEn,
  output logic                  captureEn,
  output logic [NUM_CHAINS-1:0] scanIn,
  input  logic [NUM_CHAINS-1:0] scanOut,
  output logic                  done
);
  dpStrobe_t strb;
  ctlState_t ctlState;
  logic      inHave;
  logic      accFull;
  logic      accEmpty;
  logic      canFlush;

  stwControl #(.LEN_W(LEN_W), .PAT_W(PAT_W)) u_ctl (
    .clk(clk), .rstN(rstN), .start(start), .shiftLen(shiftLen), .patCount(patCount),
    .inValid(inValid), .outReady(outReady), .inHave(inHave), .accFull(accFull),
    .accEmpty(accEmpty), .canFlush(canFlush), .outValid(outValid),
    .strb(strb), .state(ctlState), .inReady(inReady), .scanEn(scanEn),
    .scanClkEn(scanClkEn), .captureEn(captureEn), .done(done)
  );

  stwDatapath #(.FLIT_W(FLIT_W), .NUM_CHAINS(NUM_CHAINS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .inFlit(inFlit), .outReady(outReady),
    .scanOut(scanOut), .scanIn(scanIn), .inHave(inHave), .accFull(accFull),
    .accEmpty(accEmpty), .canFlush(canFlush), .outFlit(outFlit), .outValid(outValid)
  );
endmodule

// File: rtl/stwChecker.sv
module stwChecker
  import stwPkg::*;
#(
  parameter int FLIT_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input ctlState_t         state,
  input logic              scanClkEn,
  input logic              captureEn,
  input logic              inValid,
  input logic              inReady,
  input logic              outValid,
  input logic              outReady,
  input logic [FLIT_W-1:0] outFlit,
  input logic              done
);
  p_halt_freeze_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HALT_IN || state == ST_HALT_OUT) |-> !scanClkEn);

  p_take_with_shift_r2: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> scanClkEn);

  p_halt_in_exit_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HALT_IN && inValid) |=> (state == ST_SHIFT));

  p_halt_out_exit_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HALT_OUT && outReady) |=> (state == ST_SHIFT));

  p_out_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outFlit)));

  p_capture_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    captureEn |=> !captureEn);

  p_capture_no_shift_r7: assert property (@(posedge clk) disable iff (!rstN)
    captureEn |-> !scanClkEn);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_drained_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !outValid);
endmodule

bind stwWrapperCtl stwChecker #(.FLIT_W(FLIT_W)) u_chk (
  .clk(clk), .rstN(rstN), .state(ctlState), .scanClkEn(scanClkEn),
  .captureEn(captureEn), .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .outReady(outReady), .outFlit(outFlit), .done(done)
);

// File: tb/tb_stwWrapperCtl.sv
`timescale 1ns/1ps
module tb_stwWrapperCtl;
  localparam int NC = 4;
  localparam int FW = 32;
  localparam int G  = FW / NC;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rstN, start, inValid, outReady;
  logic [15:0]   shiftLen, patCount;
  logic [FW-1:0] inFlit, outFlit;
  logic          inReady, outValid, scanEn, scanClkEn, captureEn, done;
  logic [NC-1:0] scanIn, scanOut;

  stwWrapperCtl dut (
    .clk(clk), .rstN(rstN), .start(start), .shiftLen(shiftLen), .patCount(patCount),
    .inFlit(inFlit), .inValid(inValid), .inReady(inReady), .outFlit(outFlit),
    .outValid(outValid), .outReady(outReady), .scanEn(scanEn), .scanClkEn(scanClkEn),
    .captureEn(captureEn), .scanIn(scanIn), .scanOut(scanOut), .done(done)
  );

  int nChecks = 0;
  int nFail   = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // chain model: depth chainLen, inverts its contents on capture
  logic [5:0]    chainLen = 6'd1;
  logic          clrChain = 1'b0;
  logic [NC-1:0] chain [0:63];
  assign scanOut = chain[chainLen - 6'd1];
  always @(posedge clk) begin
    if (clrChain) begin
      for (int i = 0; i < 64; i++) chain[i] <= '0;
    end else if (scanClkEn) begin
      for (int i = 63; i > 0; i--) chain[i] <= chain[i-1];
      chain[0] <= scanIn;
    end else if (captureEn) begin
      for (int i = 0; i < 64; i++) chain[i] <= ~chain[i];
    end
  end

  // output ready pattern
  bit stallMode = 1'b0;
  int cycN = 0;
  initial forever begin
    @(posedge clk); #1;
    cycN++;
    outReady = stallMode ? ((cycN % 50) < 20) : 1'b1;
  end

  // monitor
  bit            running = 1'b0;
  int            shiftCount, capCount, doneCount, gotN, inTaken, doneAtN;
  logic [FW-1:0] got [0:63];
  bit            holdPend = 1'b0;
  logic [FW-1:0] holdFlit;
  always @(negedge clk) if (rstN) begin
    if (scanClkEn) shiftCount++;
    if (captureEn) capCount++;
    if (inValid && inReady) inTaken++;
    if (done) begin doneCount++; doneAtN = gotN; end
    if (outValid && outReady) begin
      if (gotN < 64) got[gotN] = outFlit;
      gotN++;
    end
    if (holdPend) begin
      check("R6 hold valid", {31'd0, outValid}, 32'd1);
      check("R6 hold data", outFlit, holdFlit);
    end
    holdPend = outValid && !outReady;
    holdFlit = outFlit;
    if (running && stallMode && (cycN % 50) == 45)
      check("R5 no shift under long output stall", {31'd0, scanClkEn}, 32'd0);
  end

  task automatic runJob(string tag, int pats, int len, bit starve, bit stall);
    int            nPhase, fpp, nFl;
    logic [FW-1:0] inData [0:63];
    logic [FW-1:0] expF   [0:63];
    nPhase = pats + 1;
    fpp    = (len * NC + FW - 1) / FW;
    nFl    = nPhase * fpp;
    for (int k = 0; k < 64; k++) begin
      inData[k] = (32'h9E3779B9 * (k + 1)) ^ (32'h5A5A0000 + len);
      expF[k]   = '0;
    end
    // response of phase p is the inverted stimulus of phase p-1 (R6 order, padding zero)
    for (int p = 1; p < nPhase; p++)
      for (int j = 0; j < len; j++)
        expF[p*fpp + j/G][(j%G)*NC +: NC] = ~inData[(p-1)*fpp + j/G][(j%G)*NC +: NC];

    @(posedge clk); #1;
    chainLen = 6'(len); shiftLen = 16'(len); patCount = 16'(pats);
    clrChain = 1'b1; stallMode = stall;
    @(posedge clk); #1;
    clrChain = 1'b0;
    shiftCount = 0; capCount = 0; doneCount = 0; gotN = 0; inTaken = 0; doneAtN = -1;
    running = 1'b1;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;

    for (int k = 0; k < nFl; k++) begin
      if (starve && (k % 2 == 1)) begin
        inValid = 1'b0;
        repeat (20) @(posedge clk);
        @(negedge clk);
        check({"R4 paused on empty input ", tag}, {30'd0, scanEn, scanClkEn}, 32'd2);
        repeat (20) @(posedge clk);
        #1;
      end
      inValid = 1'b1;
      inFlit  = inData[k];
      do @(negedge clk); while (!inReady);
      @(posedge clk); #1;
      inValid = 1'b0;
    end
    while (doneCount == 0) @(negedge clk);
    repeat (5) @(negedge clk);
    running = 1'b0;

    check({"R3 shift count ", tag}, shiftCount, nPhase * len);
    check({"R2 flits consumed ", tag}, inTaken, nFl);
    check({"R7 captures ", tag}, capCount, pats);
    check({"R9 single done ", tag}, doneCount, 1);
    check({"R9 done after drain ", tag}, doneAtN, nFl);
    check({"R6 flit count ", tag}, gotN, nFl);
    for (int k = 0; k < nFl && k < gotN; k++)
      check({"R6 response flit ", tag}, got[k], expF[k]);
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R1 reset idle outputs",
          {26'd0, inReady, outValid, scanEn, scanClkEn, captureEn, done}, 32'd0);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    rstN = 1'b0; start = 1'b0; inValid = 1'b0; inFlit = '0;
    shiftLen = 16'd1; patCount = 16'd0;
    repeat (4) @(posedge clk); #1;
    testReset();
    rstN = 1'b1;
    testReset();
    runJob("smooth R2 R6 R7", 2, 12, 1'b0, 1'b0);
    runJob("input gaps R4", 2, 12, 1'b1, 1'b0);
    runJob("output stall R5", 2, 16, 1'b0, 1'b1);
    runJob("both stalls R3 R5", 3, 12, 1'b1, 1'b1);
    runJob("no pattern R8", 0, 5, 1'b0, 1'b0);
    summary();
    $finish;
  end
endmodule